// File: doc/BRIEF.md
# Multi-Channel Reconfiguration Request Arbiter

This block sits between a set of transceiver channels and one shared reconfiguration sequencer. Each channel raises a request line and presents a channel identifier and a two-bit link-mode code. The arbiter grants one request at a time. It raises that channel's combined ack/busy line and holds it high for the whole reconfiguration. In the first cycle of the grant it pulses a start strobe to the sequencer, together with the winner's channel identifier and mode.

While a grant is open, every other request waits. The sequencer ends the grant by pulsing done, and the ack/busy line then falls. The requester is expected to drop its request as soon as it sees ack/busy. A request that stays high through the whole grant is not granted again until it has been seen low at least once.

Simultaneous requests are resolved round-robin. The search begins at the channel after the last winner and wraps around.

The controller has three states.
- `ST_IDLE` waits for an eligible request.
- `ST_START` is the single cycle in which start is driven.
- `ST_WAIT` holds the grant.

It has three transitions.
- `ST_IDLE -> ST_START` when any eligible request is present.
- `ST_START -> ST_WAIT` unconditionally.
- `ST_WAIT -> ST_IDLE` when done is sampled high.

Top module: `reconfig_req_arbiter`

## Requirements
- R1: After reset, all ack/busy outputs, start, the channel output and the mode output are 0.
- R2: A request sampled at a clock edge while idle raises the winner's ack/busy and start on that edge. Start is high for exactly one cycle.
- R3: At start, the channel output equals the winner's channel identifier and the mode output equals the winner's mode code. The codes are 00 = 1G data, 01 = 10G data, 10 = auto-negotiation and 11 = link training. Both outputs stay stable until done.
- R4: Ack/busy stays high until done is sampled in the wait state, and it falls on that edge.
- R5: While a grant is open, no other request is granted and start stays low. A pending request is granted on the edge after ack/busy falls.
- R6: Among simultaneous eligible requests, the winner is the first at or after the channel following the previous winner, wrapping at the top. After reset the search starts at channel 0.
- R7: A request that has been granted becomes eligible again only after it has been sampled low at least once.
- R8: Done is ignored while idle and in the start cycle.
- R9: At most one ack/busy output is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CH | Per-channel reconfiguration request |
| req_chan_i | input | NUM_CH*CHAN_W | Per-channel channel identifier |
| req_mode_i | input | NUM_CH*2 | Per-channel requested mode code |
| ack_busy_o | output | NUM_CH | Per-channel ack/busy, held for the whole grant |
| start_o | output | 1 | One-cycle start strobe to the sequencer |
| sel_chan_o | output | CHAN_W | Channel identifier handed to the sequencer |
| sel_mode_o | output | 2 | Mode code handed to the sequencer |
| done_i | input | 1 | Sequencer completion pulse |

## Verification
A request driven before an edge shows its grant on that same edge. Ack/busy, start and the handoff fields are therefore checked one cycle after the request is driven. Start must be low again one cycle later. Ack/busy falls on the edge that samples done, so it is checked one cycle after done is driven, and a waiting request appears on the edge after that. All inputs change on the falling clock edge and all outputs are sampled on the falling edge, so each check lands midway between the edge that produced the value and the next one.

// File: rtl/reconfig_arb_pkg.sv
package reconfig_arb_pkg;

    typedef enum logic [1:0] {
        MODE_1G  = 2'b00,
        MODE_10G = 2'b01,
        MODE_AN  = 2'b10,
        MODE_LT  = 2'b11
    } link_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/req_qualifier.sv
module req_qualifier #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] grant_vec_i,
    output logic [NUM_CH-1:0] eligible_o
);

    logic [NUM_CH-1:0] armed_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_arm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                armed_q[g] <= 1'b1;
            else if (grant_vec_i[g])
                armed_q[g] <= 1'b0;
            else if (!req_i[g])
                armed_q[g] <= 1'b1;
        end

        // R7: a grant only ever reaches a channel that is armed and requesting
        a_r7_grant_armed: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vec_i[g] |-> (armed_q[g] && req_i[g]));
    end

    assign eligible_o = req_i & armed_q;

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] eligible_i,
    input  logic [IDX_W-1:0]  ptr_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            int unsigned j;
            j = int'(ptr_i) + k;
            if (j >= NUM_CH) j = j - NUM_CH;
            if (!valid_o && eligible_i[j]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/reconfig_req_arbiter.sv
module reconfig_req_arbiter
    import reconfig_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CHAN_W = 5,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int MODE_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              req_i,
    input  logic [NUM_CH-1:0][CHAN_W-1:0]  req_chan_i,
    input  logic [NUM_CH-1:0][MODE_W-1:0]  req_mode_i,
    output logic [NUM_CH-1:0]              ack_busy_o,
    output logic                           start_o,
    output logic [CHAN_W-1:0]              sel_chan_o,
    output logic [MODE_W-1:0]              sel_mode_o,
    input  logic                           done_i
);

    arb_state_e        state_q, state_d;
    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] grant_vec;
    logic [NUM_CH-1:0] ack_q;
    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  win_idx;
    logic              win_valid;
    logic [CHAN_W-1:0] sel_chan_q;
    logic [MODE_W-1:0] sel_mode_q;
    logic              take;

    req_qualifier #(.NUM_CH(NUM_CH)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .grant_vec_i (grant_vec),
        .eligible_o  (eligible)
    );

    rr_picker #(.NUM_CH(NUM_CH)) u_pick (
        .eligible_i (eligible),
        .ptr_i      (ptr_q),
        .valid_o    (win_valid),
        .idx_o      (win_idx)
    );

    assign take = (state_q == ST_IDLE) && win_valid;

    always_comb begin
        grant_vec = '0;
        if (take) grant_vec[win_idx] = 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_valid) state_d = ST_START;
            ST_START: state_d = ST_WAIT;
            ST_WAIT:  if (done_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and handoff registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q      <= '0;
            ptr_q      <= '0;
            sel_chan_q <= '0;
            sel_mode_q <= '0;
        end else if (take) begin
            ack_q      <= grant_vec;
            sel_chan_q <= req_chan_i[win_idx];
            sel_mode_q <= req_mode_i[win_idx];
            ptr_q      <= (int'(win_idx) == NUM_CH - 1) ? '0 : win_idx + 1'b1;
        end else if (state_q == ST_WAIT && done_i) begin
            ack_q <= '0;
        end
    end

    assign ack_busy_o = ack_q;
    assign start_o    = (state_q == ST_START);
    assign sel_chan_o = sel_chan_q;
    assign sel_mode_o = sel_mode_q;

    // R9: never more than one channel holds ack/busy
    a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_q));

    // R2: start lasts one cycle and comes with exactly one grant
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r2_start_ack: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($countones(ack_q) == 1));

    // R3: handoff fields do not move while the grant is open
    a_r3_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> ($stable(sel_chan_q) && $stable(sel_mode_q)));

    // R4 / R5: without done the grant is frozen
    a_r4_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !done_i) |=> $stable(ack_q));

    // R8: done in the start cycle does not end the grant
    a_r8_start_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |=> (state_q == ST_WAIT));

endmodule

// File: tb/reconfig_req_arbiter_tb.sv
module reconfig_req_arbiter_tb;

    localparam int NUM_CH = 4;
    localparam int CHAN_W = 5;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [NUM_CH-1:0]             req_i = '0;
    logic [NUM_CH-1:0][CHAN_W-1:0] req_chan_i;
    logic [NUM_CH-1:0][1:0]        req_mode_i = '0;
    logic [NUM_CH-1:0]             ack_busy_o;
    logic                          start_o;
    logic [CHAN_W-1:0]             sel_chan_o;
    logic [1:0]                    sel_mode_o;
    logic                          done_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    reconfig_req_arbiter #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_chan_i(req_chan_i),
        .req_mode_i(req_mode_i), .ack_busy_o(ack_busy_o), .start_o(start_o),
        .sel_chan_o(sel_chan_o), .sel_mode_o(sel_mode_o), .done_i(done_i)
    );

    // each vector: {request mask, expected winner}
    localparam logic [7:0] VEC [8] = '{
        {4'b0001, 4'd0}, {4'b1111, 4'd1}, {4'b1111, 4'd2}, {4'b1111, 4'd3},
        {4'b1010, 4'd1}, {4'b0011, 4'd0}, {4'b1000, 4'd3}, {4'b0110, 4'd1}
    };

    function automatic logic [CHAN_W-1:0] chan_of(int i);
        return CHAN_W'(i * 7 + 3);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_grant();
        done_i = 1'b1;
        tick();
        done_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NUM_CH; i++) req_chan_i[i] = chan_of(i);
        tick(); tick();
        chk("R1 ack after reset", 32'(ack_busy_o), 0);
        chk("R1 start after reset", 32'(start_o), 0);
        chk("R1 chan after reset", 32'(sel_chan_o), 0);
        chk("R1 mode after reset", 32'(sel_mode_o), 0);
        rst_n = 1'b1;
        tick();

        // table walk: R2 R3 R4 R6 R9
        for (int k = 0; k < 8; k++) begin
            int w;
            w = int'(VEC[k][3:0]);
            req_i = VEC[k][7:4];
            for (int i = 0; i < NUM_CH; i++) req_mode_i[i] = 2'(k);
            tick();
            chk("R6/R9 winner ack", 32'(ack_busy_o), 32'(1 << w));
            chk("R2 start high", 32'(start_o), 1);
            chk("R3 channel", 32'(sel_chan_o), 32'(chan_of(w)));
            chk("R3 mode", 32'(sel_mode_o), 32'(k % 4));
            req_i = '0;
            for (int i = 0; i < NUM_CH; i++) req_mode_i[i] = 2'(k + 1);
            tick();
            chk("R2 start one cycle", 32'(start_o), 0);
            tick();
            chk("R4 ack held", 32'(ack_busy_o), 32'(1 << w));
            chk("R3 mode held", 32'(sel_mode_o), 32'(k % 4));
            finish_grant();
            chk("R4 ack released", 32'(ack_busy_o), 0);
            tick();
        end

        // R8: done while idle and in the start cycle
        done_i = 1'b1;
        tick();
        done_i = 1'b0;
        chk("R8 idle done no ack", 32'(ack_busy_o), 0);
        req_i = 4'b0100;
        req_mode_i[2] = 2'b11;
        tick();
        chk("R8 grant ch2", 32'(ack_busy_o), 32'b0100);
        req_i = '0;
        done_i = 1'b1;
        tick();
        done_i = 1'b0;
        chk("R8 done in start ignored", 32'(ack_busy_o), 32'b0100);

        // R5: another request waits for the grant to close
        req_i = 4'b0010;
        req_mode_i[1] = 2'b10;
        repeat (4) tick();
        chk("R5 no second grant", 32'(ack_busy_o), 32'b0100);
        chk("R5 no start while busy", 32'(start_o), 0);
        finish_grant();
        chk("R5 ack falls", 32'(ack_busy_o), 0);
        tick();
        chk("R5 pending granted", 32'(ack_busy_o), 32'b0010);
        chk("R5 pending mode", 32'(sel_mode_o), 32'b10);
        req_i = '0;
        tick();
        finish_grant();

        // R7: request held high through grant is not re-granted
        req_i = 4'b0001;
        tick();
        chk("R7 first grant", 32'(ack_busy_o), 32'b0001);
        tick(); tick();
        finish_grant();
        repeat (3) tick();
        chk("R7 held request not regranted", 32'(ack_busy_o), 0);
        chk("R7 no start", 32'(start_o), 0);
        req_i = '0;
        tick();
        req_i = 4'b0001;
        tick();
        chk("R7 regrant after low", 32'(ack_busy_o), 32'b0001);
        req_i = '0;
        tick();
        finish_grant();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule